// File: doc/BRIEF.md
# Error Pin Low-Time Controller

This block drives an active-low error pin for a safety-monitoring subsystem. When a hardware error event or a software-forced error arrives, the pin goes low and a down-counter is loaded from a preload register. The counter then steps down once per clock while the pin is low. The pin is released only after the counter has reached zero and software has issued a clear request. As a result, every error produces a low pulse of guaranteed minimum length, which external supervisors can detect reliably.

The preload register has four settings. Its upper two bits can be written, and the bits below them are hard-wired to ones. Writes succeed only when the bus access is marked privileged. Both the live counter and the effective preload can be read through a simple single-cycle 32-bit register bus. The bus has no handshake: a write takes effect on the edge where `bus_wr` is sampled high, and `bus_rdata` follows `bus_addr` combinationally. The error and clear inputs are plain level-sampled control pins.

Top module: `errpin_lowtime`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the pin is high and both the counter and the preload read 0x3FFF (upper field 00, all lower bits ones).
- R2: If `err_hw` or `err_force` is high at a clock edge, the pin is low after that edge and the counter holds the preload value from before that edge, even when a preload write lands on the same edge.
- R3: While the pin is low and no error arrives, the counter drops by exactly one per clock. It stays at zero once there, and it does not change while the pin is high.
- R4: An error that arrives while the counter is still running reloads the counter from the preload.
- R5: The pin goes high on the first edge where the counter already reads zero and a clear request is pending or present. With the clear held from the start, the pin is low for exactly preload+1 cycles. Without a clear, the pin stays low indefinitely.
- R6: A clear request has no effect when it is given while the pin is high or on the same edge as an error. A new error cancels any clear that is still pending.
- R7: A privileged write to byte offset 0x4 copies `bus_wdata[15:14]` into preload bits 15:14. Preload bits 13:0 always read as ones.
- R8: A write with `bus_priv` low leaves the preload unchanged. Any write to offset 0x0 leaves the counter unchanged.
- R9: Offset 0x0 reads the counter and offset 0x4 reads the preload, each zero-extended so that bits 31:16 are zero. Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_hw | input | 1 | Hardware error event |
| err_force | input | 1 | Software-forced error |
| err_clear | input | 1 | Request to release the pin |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_priv | input | 1 | Access is privileged |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| err_pin_n | output | 1 | Active-low error pin |

## Verification
The assertions check the following on every cycle:
- the pin falls and the counter reloads from the previous preload after each error;
- the counter steps down by one without wrapping and stays frozen while the pin is high;
- the pin rises only from a zero count;
- unprivileged writes leave the preload unchanged;
- read data is zero-extended.

Some behaviour can only be shown by the bench's scenarios: the exact low-pulse length for each of the four preload settings, how clear requests that are early, late, cancelled or ignored change the release edge, and the priority between a preload write and an error on the same edge.

// File: rtl/errpin_pkg.sv
package errpin_pkg;
  localparam int unsigned BUS_W       = 32;
  localparam int unsigned OFS_COUNTER = 0;
  localparam int unsigned OFS_PRELOAD = 4;

  typedef struct packed {
    logic       wr;
    logic       priv;
    logic [3:0] addr;
  } bus_ctl_t;
endpackage

// File: rtl/lt_preload_reg.sv
module lt_preload_reg #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned WR_BITS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WR_BITS-1:0] wr_field,
  output logic [CNT_W-1:0]   preload_o
);
  localparam int unsigned FIX_W = CNT_W - WR_BITS;

  logic [WR_BITS-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (wr_en) sel_q <= wr_field;
  end

  generate
    if (FIX_W > 0) begin : g_fixed
      assign preload_o = {sel_q, {FIX_W{1'b1}}};
    end else begin : g_full
      assign preload_o = sel_q;
    end
  endgenerate
endmodule

// File: rtl/lt_down_counter.sv
module lt_down_counter #(
  parameter int unsigned CNT_W = 16,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= RST_VAL;
    else if (load)            cnt_q <= load_val;
    else if (run && !zero_o)  cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/lt_pin_ctrl.sv
module lt_pin_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic err_evt,
  input  logic clr_req,
  input  logic cnt_zero,
  output logic pin_low_o
);
  logic low_q;
  logic clr_pend_q;
  logic release_now;

  assign release_now = low_q && cnt_zero && (clr_pend_q || clr_req) && !err_evt;
  assign pin_low_o   = low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q      <= 1'b0;
      clr_pend_q <= 1'b0;
    end else begin
      if (err_evt)          low_q <= 1'b1;
      else if (release_now) low_q <= 1'b0;

      if (err_evt || release_now) clr_pend_q <= 1'b0;
      else if (low_q && clr_req)  clr_pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/errpin_lowtime.sv
module errpin_lowtime #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned WR_BITS = 2,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        err_hw,
  input  logic        err_force,
  input  logic        err_clear,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_priv,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        err_pin_n
);
  import errpin_pkg::*;

  localparam int unsigned FIX_W = CNT_W - WR_BITS;
  localparam logic [CNT_W-1:0] PRE_RST = CNT_W'((64'(1) << FIX_W) - 64'(1));
  localparam logic [31:0] FIELD_MASK = 32'(((64'(1) << WR_BITS) - 64'(1)) << FIX_W);

  logic             err_evt;
  logic             pre_wr;
  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;
  logic             pin_low;
  logic [31:0]      wdata_unused;

  assign err_evt      = err_hw | err_force;
  assign pre_wr       = bus_wr && bus_priv && (bus_addr == ADDR_W'(OFS_PRELOAD));
  assign wdata_unused = bus_wdata & ~FIELD_MASK;

  lt_preload_reg #(.CNT_W(CNT_W), .WR_BITS(WR_BITS)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (pre_wr),
    .wr_field  (bus_wdata[CNT_W-1 -: WR_BITS]),
    .preload_o (pre_q)
  );

  lt_down_counter #(.CNT_W(CNT_W), .RST_VAL(PRE_RST)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (err_evt),
    .load_val (pre_q),
    .run      (pin_low),
    .cnt_o    (cnt_q),
    .zero_o   (cnt_zero)
  );

  lt_pin_ctrl u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_evt   (err_evt),
    .clr_req   (err_clear),
    .cnt_zero  (cnt_zero),
    .pin_low_o (pin_low)
  );

  assign err_pin_n = ~pin_low;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_COUNTER))      bus_rdata = 32'(cnt_q);
    else if (bus_addr == ADDR_W'(OFS_PRELOAD)) bus_rdata = 32'(pre_q);
  end
endmodule

// File: rtl/errpin_lowtime_chk.sv
module errpin_lowtime_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err_hw,
  input logic              err_force,
  input logic              bus_wr,
  input logic              bus_priv,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              err_pin_n,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  pre_q
);
  logic evt;
  assign evt = err_hw | err_force;

  a_r2_pin_falls: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !err_pin_n);

  a_r2_loads_old_preload: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> cnt_q == $past(pre_q));

  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !err_pin_n && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && cnt_q == '0) |=> cnt_q == '0);

  a_r3_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && err_pin_n) |=> $stable(cnt_q));

  a_r5_rise_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_pin_n) |-> $past(cnt_q) == '0);

  a_r8_unpriv_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_priv) |=> $stable(pre_q));

  a_r9_counter_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(0)) |-> bus_rdata == 32'(cnt_q));

  a_r9_preload_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(4)) |-> bus_rdata == 32'(pre_q));
endmodule

bind errpin_lowtime errpin_lowtime_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .err_hw    (err_hw),
  .err_force (err_force),
  .bus_wr    (bus_wr),
  .bus_priv  (bus_priv),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .err_pin_n (err_pin_n),
  .cnt_q     (cnt_q),
  .pre_q     (pre_q)
);

// File: tb/sim_errpin_lowtime.sv
module sim_errpin_lowtime;
  localparam int CW = 6;
  localparam int WB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_hw = 1'b0, err_force = 1'b0, err_clear = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_priv = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic err_pin_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  errpin_lowtime #(.CNT_W(CW), .WR_BITS(WB), .ADDR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .err_hw(err_hw), .err_force(err_force),
    .err_clear(err_clear), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_priv(bus_priv), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .err_pin_n(err_pin_n)
  );

  function automatic int pre_of(input int sel);
    return sel * 16 + 15;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic p);
    bus_addr = a; bus_wdata = d; bus_priv = p; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0; bus_priv = 1'b0;
  endtask

  task automatic err_pulse();
    err_hw = 1'b1;
    tick();
    err_hw = 1'b0;
  endtask

  task automatic clr_pulse();
    err_clear = 1'b1;
    tick();
    err_clear = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int p;
    repeat (2) tick();
    chk("R1 pin in reset", 32'(err_pin_n), 32'd1);
    rd(4'h0, d); chk("R1 counter in reset", d, 32'h0F);
    rd(4'h4, d); chk("R1 preload in reset", d, 32'h0F);
    rst_n = 1'b1;
    tick();
    chk("R1 pin after reset", 32'(err_pin_n), 32'd1);
    rd(4'h0, d); chk("R1 counter after reset", d, 32'h0F);

    // R5/R7: full low pulse for each preload setting, clear held throughout
    for (int s = 0; s < 4; s++) begin
      p = pre_of(s);
      wr(4'h4, 32'(s) << 4, 1'b1);
      rd(4'h4, d); chk("R7 preload write", d, 32'(p));
      if (s % 2 == 1) err_force = 1'b1; else err_hw = 1'b1;
      tick();
      err_force = 1'b0; err_hw = 1'b0; err_clear = 1'b1;
      for (int k = 0; k <= p; k++) begin
        rd(4'h0, d); chk("R3 countdown", d, 32'(p - k));
        chk("R2 pin low", 32'(err_pin_n), 32'd0);
        tick();
      end
      chk("R5 release after preload+1 cycles", 32'(err_pin_n), 32'd1);
      err_clear = 1'b0;
      tick();
      rd(4'h0, d); chk("R3 stays zero when idle", d, 32'd0);
    end

    wr(4'h4, 32'h0, 1'b1);
    p = 15;

    // R5: no clear -> stuck low, then clear releases
    err_pulse();
    repeat (p + 5) tick();
    rd(4'h0, d); chk("R3 no wrap", d, 32'd0);
    chk("R5 held low without clear", 32'(err_pin_n), 32'd0);
    clr_pulse();
    chk("R5 release on clear at zero", 32'(err_pin_n), 32'd1);

    // R5: early clear pulse remembered
    err_pulse();
    tick(); tick();
    clr_pulse();
    repeat (p - 4) tick();
    rd(4'h0, d); chk("R3 count at one", d, 32'd1);
    tick();
    chk("R5 low while reaching zero", 32'(err_pin_n), 32'd0);
    tick();
    chk("R5 early clear releases", 32'(err_pin_n), 32'd1);

    // R4: reload mid-count
    err_pulse();
    repeat (3) tick();
    rd(4'h0, d); chk("R3 mid-count", d, 32'(p - 3));
    err_pulse();
    rd(4'h0, d); chk("R4 reload", d, 32'(p));
    tick();
    rd(4'h0, d); chk("R4 resumes", d, 32'(p - 1));

    // R6: new error discards pending clear
    clr_pulse();
    err_pulse();
    repeat (p + 3) tick();
    chk("R6 pending clear discarded", 32'(err_pin_n), 32'd0);
    clr_pulse();
    chk("R6 later clear releases", 32'(err_pin_n), 32'd1);

    // R6: clear while pin high ignored
    clr_pulse();
    err_pulse();
    repeat (p + 3) tick();
    chk("R6 clear while high ignored", 32'(err_pin_n), 32'd0);
    clr_pulse();

    // R6: clear on same edge as error ignored
    err_hw = 1'b1; err_clear = 1'b1;
    tick();
    err_hw = 1'b0; err_clear = 1'b0;
    repeat (p + 3) tick();
    chk("R6 clear with error ignored", 32'(err_pin_n), 32'd0);
    clr_pulse();
    chk("R6 release", 32'(err_pin_n), 32'd1);

    // R8: unprivileged and counter writes ignored
    wr(4'h4, 32'h30, 1'b0);
    rd(4'h4, d); chk("R8 unprivileged write ignored", d, 32'h0F);
    wr(4'h0, 32'hFFFF_FFFF, 1'b1);
    rd(4'h0, d); chk("R8 counter write ignored", d, 32'd0);

    // R2: write and error on the same edge -> old preload loaded
    bus_addr = 4'h4; bus_wdata = 32'h30; bus_priv = 1'b1; bus_wr = 1'b1; err_hw = 1'b1;
    tick();
    bus_wr = 1'b0; bus_priv = 1'b0; err_hw = 1'b0;
    rd(4'h0, d); chk("R2 old preload on collision", d, 32'h0F);
    rd(4'h4, d); chk("R7 collision write landed", d, 32'h3F);
    err_clear = 1'b1;
    repeat (20) tick();
    err_clear = 1'b0;
    chk("R5 released", 32'(err_pin_n), 32'd1);

    // R9: read map
    wr(4'h4, 32'hFFFF_FFFF, 1'b1);
    rd(4'h4, d); chk("R9 preload zero-extended", d, 32'h3F);
    rd(4'h8, d); chk("R9 unmapped offset", d, 32'd0);
    rd(4'hC, d); chk("R9 unmapped offset C", d, 32'd0);
    err_pulse();
    rd(4'h0, d); chk("R9 counter zero-extended", d, 32'h3F);

    // R1: reset mid-pulse
    rst_n = 1'b0;
    #2;
    chk("R1 pin after async reset", 32'(err_pin_n), 32'd1);
    rd(4'h0, d); chk("R1 counter after async reset", d, 32'h0F);
    rd(4'h4, d); chk("R1 preload after async reset", d, 32'h0F);
    tick();
    rst_n = 1'b1;
    tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule